// File: doc/BRIEF.md
# Four-Stage Integer Pipeline with Token-Based Flush

This block is a small in-order RV32 integer core that executes four instructions: ADD, signed branch-if-less-than (BLT), word load (LW) and word store (SW). The core has four stages. Fetch presents the program counter on a combinational instruction port. Decode reads the register file. Execute computes sums, compares, redirects and drives memory. Writeback retires results into the register file. Results reach the Execute operands by forwarding, so dependent ADDs can run back to back. An instruction that needs a loaded word in the next slot waits one cycle. All other bit patterns decode to a no-op.

Only Execute can redirect the core. None of the stages carries a valid bit. Execute instead holds a two-state controller with the states Run and Drain. A taken branch sends the target to Fetch and moves the controller to Drain. Fetch marks the first instruction it fetches from the target with a token. Until that marked instruction reaches Execute, every arrival there is stripped of its side effects. The marked instruction then executes in full and sets the controller back to Run.

The data port is single-cycle. Address, write data and write strobe come straight from Execute. The read word is returned on the clock edge that follows and is consumed in Writeback.

Top module: `tok_pipe_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, imem_addr is 0 and dmem_we is 0; the controller starts in Run with no token pending.
- R2: With no redirect and no load-use wait, imem_addr advances by 4 every cycle.
- R3: ADD (opcode 0110011, funct3 000, funct7 0) writes rs1+rs2 modulo 2^32 to rd, and the result is forwarded so that the next instruction can use it without a wait.
- R4: LW (opcode 0000011, funct3 010) and SW (opcode 0100011, funct3 010) use the address rs1 plus the sign-extended 12-bit offset. SW raises dmem_we with dmem_wdata = rs2 during its Execute cycle.
- R5: BLT (opcode 1100011, funct3 100) compares signed values and is taken when rs1 < rs2. A taken BLT puts PC + sign-extended B-offset on imem_addr in the next cycle. A BLT that is not taken changes nothing.
- R6: After a taken branch, each instruction that reaches Execute before the token does not store, does not write a register and does not redirect.
- R7: The token-marked instruction executes normally, and this includes a taken BLT, a store and an ADD. After it, the controller is back in Run.
- R8: Writes to x0 are dropped, and x0 reads as 0 on both the register-file path and the forwarding path.
- R9: When an instruction uses the rd of an LW directly ahead of it, Fetch and Decode hold for exactly one cycle. The loaded word then reaches that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Word read at the previous cycle's dmem_addr |

## Verification
The bench runs a program that loads its constants, chains dependent ADDs, and stores results so they can be seen on the data port. A core with missing or misdirected forwarding would store wrong sums. A core that mishandled x0 would store a stale sum in place of an operand. A core that compared unsigned values would skip the branch on -3 < 5. Stores sit on every wrong path, including the slots behind a token-marked BLT that is itself taken, so a controller that executed during Drain, or one that left Drain early, would emit extra stores. The fetch-address trace shows whether the load-use wait is too short or too long and whether a redirect arrives exactly one cycle after the branch.

// File: rtl/tp_pkg.sv
package tp_pkg;

   localparam int XW = 32;
   localparam int RW = 5;

   localparam logic [6:0] OPC_ALU    = 7'b0110011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;

   typedef enum logic [2:0] {OP_NONE, OP_ADD, OP_BLT, OP_LW, OP_SW} op_e;

   typedef enum logic {CTL_RUN, CTL_DRAIN} ctl_e;

   typedef struct packed {
      op_e            op;
      logic [RW-1:0]  rd;
      logic [RW-1:0]  rs1;
      logic [RW-1:0]  rs2;
      logic [XW-1:0]  imm;
   } uop_t;

   localparam uop_t UOP_BUBBLE = '{op: OP_NONE, rd: '0, rs1: '0, rs2: '0, imm: '0};

   // Unused source fields are forced to x0 so they never match a hazard.
   function automatic uop_t decode_instr(input logic [XW-1:0] w);
      uop_t u;
      u = UOP_BUBBLE;
      unique case (w[6:0])
         OPC_ALU: if (w[14:12] == 3'b000 && w[31:25] == 7'b0) begin
            u.op  = OP_ADD;
            u.rd  = w[11:7];
            u.rs1 = w[19:15];
            u.rs2 = w[24:20];
         end
         OPC_BRANCH: if (w[14:12] == 3'b100) begin
            u.op  = OP_BLT;
            u.rs1 = w[19:15];
            u.rs2 = w[24:20];
            u.imm = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
         end
         OPC_LOAD: if (w[14:12] == 3'b010) begin
            u.op  = OP_LW;
            u.rd  = w[11:7];
            u.rs1 = w[19:15];
            u.imm = {{20{w[31]}}, w[31:20]};
         end
         OPC_STORE: if (w[14:12] == 3'b010) begin
            u.op  = OP_SW;
            u.rs1 = w[19:15];
            u.rs2 = w[24:20];
            u.imm = {{20{w[31]}}, w[31:25], w[11:7]};
         end
         default: u = UOP_BUBBLE;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/tp_fetch.sv
module tp_fetch #(
   parameter int               XLEN     = 32,
   parameter logic [XLEN-1:0]  RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall,
   input  logic            restart,
   input  logic [XLEN-1:0] restart_pc,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [XLEN-1:0] fd_instr,
   output logic [XLEN-1:0] fd_pc,
   output logic            fd_tok
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] pc;
   logic            tok_pend;

   assign imem_addr = pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc       <= RESET_PC;
         tok_pend <= 1'b0;
         fd_instr <= '0;
         fd_pc    <= '0;
         fd_tok   <= 1'b0;
      end else if (restart) begin
         // the word fetched this cycle is off-path and will be drained
         pc       <= restart_pc;
         tok_pend <= 1'b1;
         fd_instr <= imem_rdata;
         fd_pc    <= pc;
         fd_tok   <= 1'b0;
      end else if (!stall) begin
         pc       <= pc + STEP;
         tok_pend <= 1'b0;
         fd_instr <= imem_rdata;
         fd_pc    <= pc;
         fd_tok   <= tok_pend;
      end
   end

endmodule

// File: rtl/tp_regfile.sv
module tp_regfile #(
   parameter int NREGS          = 32,
   parameter int XLEN           = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2
);

   logic [XLEN-1:0] regs [NREGS];
   logic            wr_ok;

   assign wr_ok = we && (wa != '0);

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < NREGS; i++) regs[i] <= '0;
            end else if (wr_ok) begin
               regs[wa] <= wd;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_ok && rst_n) regs[wa] <= wd;
         end
      end
   endgenerate

   // same-cycle write bypass; x0 always zero
   always_comb begin
      if (ra1 == '0)                 rd1 = '0;
      else if (wr_ok && wa == ra1)   rd1 = wd;
      else                           rd1 = regs[ra1];
      if (ra2 == '0)                 rd2 = '0;
      else if (wr_ok && wa == ra2)   rd2 = wd;
      else                           rd2 = regs[ra2];
   end

endmodule

// File: rtl/tp_decode.sv
module tp_decode
   import tp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] fd_instr,
   input  logic [XLEN-1:0] fd_pc,
   input  logic            fd_tok,
   input  logic [RW-1:0]   x_ld_rd,
   output logic [RW-1:0]   rf_ra1,
   output logic [RW-1:0]   rf_ra2,
   input  logic [XLEN-1:0] rf_rd1,
   input  logic [XLEN-1:0] rf_rd2,
   output logic            stall,
   output uop_t            dx_uop,
   output logic [XLEN-1:0] dx_pc,
   output logic [XLEN-1:0] dx_a,
   output logic [XLEN-1:0] dx_b,
   output logic            dx_tok
);

   uop_t cur;

   assign cur    = decode_instr(fd_instr);
   assign rf_ra1 = cur.rs1;
   assign rf_ra2 = cur.rs2;

   // load-use: X holds an active LW whose rd this instruction reads
   assign stall = (x_ld_rd != '0) && ((cur.rs1 == x_ld_rd) || (cur.rs2 == x_ld_rd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dx_uop <= UOP_BUBBLE;
         dx_pc  <= '0;
         dx_a   <= '0;
         dx_b   <= '0;
         dx_tok <= 1'b0;
      end else if (stall) begin
         dx_uop <= UOP_BUBBLE;
         dx_tok <= 1'b0;
      end else begin
         dx_uop <= cur;
         dx_pc  <= fd_pc;
         dx_a   <= rf_rd1;
         dx_b   <= rf_rd2;
         dx_tok <= fd_tok;
      end
   end

endmodule

// File: rtl/tp_execute.sv
module tp_execute
   import tp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  uop_t            dx_uop,
   input  logic [XLEN-1:0] dx_pc,
   input  logic [XLEN-1:0] dx_a,
   input  logic [XLEN-1:0] dx_b,
   input  logic            dx_tok,
   output logic            restart,
   output logic [XLEN-1:0] restart_pc,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic [RW-1:0]   x_ld_rd,
   output logic            x_flushing,
   output logic            wb_we,
   output logic [RW-1:0]   wb_rd,
   output logic [XLEN-1:0] wb_val
);

   ctl_e            state;
   logic            act;
   logic [XLEN-1:0] opa, opb, sum;
   logic            less;
   logic            w_is_ld;
   logic [XLEN-1:0] w_alu;

   // the token-marked arrival is live even while draining
   assign act        = (state == CTL_RUN) || dx_tok;
   assign x_flushing = (state == CTL_DRAIN);

   assign wb_val = w_is_ld ? dmem_rdata : w_alu;

   // operand forwarding from Writeback
   always_comb begin
      opa = dx_a;
      opb = dx_b;
      if (wb_we && dx_uop.rs1 != '0 && wb_rd == dx_uop.rs1) opa = wb_val;
      if (wb_we && dx_uop.rs2 != '0 && wb_rd == dx_uop.rs2) opb = wb_val;
   end

   assign sum  = opa + opb;
   assign less = $signed(opa) < $signed(opb);

   assign restart    = act && (dx_uop.op == OP_BLT) && less;
   assign restart_pc = dx_pc + dx_uop.imm;

   assign dmem_addr  = opa + dx_uop.imm;
   assign dmem_wdata = opb;
   assign dmem_we    = act && (dx_uop.op == OP_SW);

   assign x_ld_rd = (act && dx_uop.op == OP_LW) ? dx_uop.rd : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= CTL_RUN;
         wb_we   <= 1'b0;
         wb_rd   <= '0;
         w_is_ld <= 1'b0;
         w_alu   <= '0;
      end else begin
         if (restart)     state <= CTL_DRAIN;
         else if (dx_tok) state <= CTL_RUN;
         wb_we   <= act && (dx_uop.op == OP_ADD || dx_uop.op == OP_LW) && (dx_uop.rd != '0);
         wb_rd   <= dx_uop.rd;
         w_is_ld <= (dx_uop.op == OP_LW);
         w_alu   <= sum;
      end
   end

endmodule

// File: rtl/tok_pipe_core.sv
module tok_pipe_core
   import tp_pkg::*;
#(
   parameter int               XLEN           = 32,
   parameter int               NREGS          = 32,
   parameter logic [XLEN-1:0]  RESET_PC       = '0,
   parameter bit               RF_CLEAR_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata
);

   localparam int RAW = $clog2(NREGS);

   initial begin
      if (XLEN != XW)          $fatal(1, "XLEN must equal %0d", XW);
      if (NREGS != 32)         $fatal(1, "NREGS must be 32");
      if (RAW != RW)           $fatal(1, "register index width mismatch");
      if (RESET_PC[1:0] != 0)  $fatal(1, "RESET_PC must be word aligned");
   end

   logic            stall;
   logic            restart;
   logic [XLEN-1:0] restart_pc;
   logic [XLEN-1:0] fd_instr, fd_pc;
   logic            fd_tok;
   logic [RW-1:0]   rf_ra1, rf_ra2;
   logic [XLEN-1:0] rf_rd1, rf_rd2;
   uop_t            dx_uop;
   logic [XLEN-1:0] dx_pc, dx_a, dx_b;
   logic            dx_tok;
   logic [RW-1:0]   x_ld_rd;
   logic            x_flushing;
   logic            wb_we;
   logic [RW-1:0]   wb_rd;
   logic [XLEN-1:0] wb_val;

   tp_fetch #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_fetch (
      .clk(clk), .rst_n(rst_n), .stall(stall), .restart(restart),
      .restart_pc(restart_pc), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .fd_instr(fd_instr), .fd_pc(fd_pc), .fd_tok(fd_tok)
   );

   tp_regfile #(.NREGS(NREGS), .XLEN(XLEN), .CLEAR_ON_RESET(RF_CLEAR_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(wb_we), .wa(wb_rd), .wd(wb_val),
      .ra1(rf_ra1), .ra2(rf_ra2), .rd1(rf_rd1), .rd2(rf_rd2)
   );

   tp_decode #(.XLEN(XLEN)) u_dec (
      .clk(clk), .rst_n(rst_n), .fd_instr(fd_instr), .fd_pc(fd_pc),
      .fd_tok(fd_tok), .x_ld_rd(x_ld_rd), .rf_ra1(rf_ra1), .rf_ra2(rf_ra2),
      .rf_rd1(rf_rd1), .rf_rd2(rf_rd2), .stall(stall), .dx_uop(dx_uop),
      .dx_pc(dx_pc), .dx_a(dx_a), .dx_b(dx_b), .dx_tok(dx_tok)
   );

   tp_execute #(.XLEN(XLEN)) u_exe (
      .clk(clk), .rst_n(rst_n), .dx_uop(dx_uop), .dx_pc(dx_pc),
      .dx_a(dx_a), .dx_b(dx_b), .dx_tok(dx_tok), .restart(restart),
      .restart_pc(restart_pc), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
      .dmem_we(dmem_we), .dmem_rdata(dmem_rdata), .x_ld_rd(x_ld_rd),
      .x_flushing(x_flushing), .wb_we(wb_we), .wb_rd(wb_rd), .wb_val(wb_val)
   );

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] imem_addr,
   input logic            restart,
   input logic [XLEN-1:0] restart_pc,
   input logic            x_flushing,
   input logic            x_tok,
   input logic            stall,
   input logic            dmem_we,
   input logic            wb_we,
   input logic [4:0]      wb_rd
);

   assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> imem_addr == RESET_PC);

   assert_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> imem_addr == $past(restart_pc));

   assert_enter_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> x_flushing);

   assert_drain_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (x_flushing && !x_tok) |-> (!dmem_we && !restart));

   assert_drain_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (x_flushing && !x_tok) |=> !wb_we);

   assert_token_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (x_flushing && x_tok && !restart) |=> !x_flushing);

   assert_hold_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !restart) |=> $stable(imem_addr));

   assert_no_x0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> wb_rd != 5'd0);

endmodule

bind tok_pipe_core tp_checker #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
   .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .restart(restart),
   .restart_pc(restart_pc), .x_flushing(x_flushing), .x_tok(dx_tok),
   .stall(stall), .dmem_we(dmem_we), .wb_we(wb_we), .wb_rd(wb_rd)
);

// File: tb/tb_tok_pipe_core.sv
module tb_tok_pipe_core;

   localparam int CLK_PERIOD = 10;
   localparam int TRACE_LEN  = 150;
   localparam int N_EXP      = 9;

   // expected stores {byte address, data}, in program order
   localparam logic [63:0] EXP_ST [N_EXP] = '{
      {32'd64,  32'd36},          // R3 chained ADDs, R4 store
      {32'd68,  32'd24},          // R3 forwarded operand
      {32'd72,  32'd5},           // R8 x0 read as zero
      {32'd84,  32'hFFFF_FFFD},   // R7 token-marked store, R9 loaded word
      {32'd88,  32'd5},           // R5 branch not taken
      {32'd92,  32'd1},           // R7 token ADD at loop head
      {32'd92,  32'd2},
      {32'd92,  32'd3},
      {32'd104, 32'd3}            // R7 token BLT that is itself taken
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] rom  [64];
   logic [31:0] dram [64];
   logic [31:0] pc_trace [TRACE_LEN];
   logic [31:0] st_a [32];
   logic [31:0] st_d [32];
   int          cyc = 0;
   int          nst = 0;
   bit          tracing = 1'b0;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tok_pipe_core dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata)
   );

   assign imem_rdata = rom[imem_addr[7:2]];

   always @(posedge clk) begin
      if (dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;
      dmem_rdata <= dram[dmem_addr[7:2]];
   end

   always @(negedge clk) begin
      if (tracing) begin
         if (cyc < TRACE_LEN) pc_trace[cyc] = imem_addr;
         if (dmem_we) begin
            if (nst < 32) begin
               st_a[nst] = dmem_addr;
               st_d[nst] = dmem_wdata;
            end
            nst++;
         end
         cyc++;
      end
   end

   function automatic logic [31:0] e_add(int rd, int rs1, int rs2);
      return {7'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] e_lw(int rd, int rs1, int off);
      logic [11:0] i = 12'(off);
      return {i, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
   endfunction
   function automatic logic [31:0] e_sw(int rs2, int rs1, int off);
      logic [11:0] i = 12'(off);
      return {i[11:5], 5'(rs2), 5'(rs1), 3'b010, i[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] e_blt(int rs1, int rs2, int off);
      logic [12:0] i = 13'(off);
      return {i[12], i[10:5], 5'(rs2), 5'(rs1), 3'b100, i[4:1], i[11], 7'b1100011};
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", what, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired (all requirements) actual %0d expected %0d", cyc, TRACE_LEN);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int k52;
      bit found;
      for (int i = 0; i < 64; i++) begin
         rom[i]  = 32'h0000_0013;   // unsupported encoding, acts as no-op
         dram[i] = '0;
      end
      dram[0] = 32'd5; dram[1] = 32'd7; dram[2] = 32'hFFFF_FFFD;
      dram[3] = 32'd1; dram[4] = 32'd3;

      rom[0]  = e_lw(1, 0, 0);
      rom[1]  = e_lw(2, 0, 4);
      rom[2]  = e_add(3, 1, 2);      // load-use wait
      rom[3]  = e_add(4, 3, 3);
      rom[4]  = e_add(5, 4, 3);
      rom[5]  = e_sw(5, 0, 64);
      rom[6]  = e_sw(4, 0, 68);
      rom[7]  = e_add(0, 1, 2);      // write to x0 dropped
      rom[8]  = e_add(6, 0, 1);
      rom[9]  = e_sw(6, 0, 72);
      rom[10] = e_lw(7, 0, 8);
      rom[11] = e_blt(7, 1, 12);     // -3 < 5 signed, taken to 56
      rom[12] = e_sw(1, 0, 76);      // off-path
      rom[13] = e_sw(2, 0, 80);      // off-path
      rom[14] = e_sw(7, 0, 84);
      rom[15] = e_blt(1, 7, 8);      // 5 < -3 false
      rom[16] = e_sw(1, 0, 88);
      rom[17] = e_lw(9, 0, 12);
      rom[18] = e_lw(10, 0, 16);
      rom[19] = e_add(8, 8, 9);      // loop head
      rom[20] = e_sw(8, 0, 92);
      rom[21] = e_blt(8, 10, -8);
      rom[22] = e_blt(0, 9, 8);      // taken to 96
      rom[23] = e_sw(1, 0, 96);      // off-path
      rom[24] = e_blt(0, 9, 8);      // token instruction, taken to 104
      rom[25] = e_sw(1, 0, 100);     // off-path
      rom[26] = e_sw(10, 0, 104);
      rom[27] = e_blt(0, 9, 0);      // spin

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(imem_addr == 32'd0, "R1 imem_addr in reset", imem_addr, 32'd0);
      chk(dmem_we == 1'b0, "R1 dmem_we in reset", 32'(dmem_we), 32'd0);
      #1;
      rst_n   = 1'b1;
      tracing = 1'b1;
      chk(imem_addr == 32'd0, "R1 imem_addr after release", imem_addr, 32'd0);

      repeat (TRACE_LEN + 1) @(negedge clk);
      #1;

      chk(pc_trace[0] == 32'd4, "R2 fetch step 1", pc_trace[0], 32'd4);
      chk(pc_trace[1] == 32'd8, "R2 fetch step 2", pc_trace[1], 32'd8);
      chk(pc_trace[2] == 32'd12 && pc_trace[3] == 32'd12, "R9 one-cycle hold at 12",
          pc_trace[3], 32'd12);
      chk(pc_trace[4] == 32'd16, "R9 hold lasts one cycle", pc_trace[4], 32'd16);

      found = 1'b0;
      k52   = 0;
      for (int k = 3; k < TRACE_LEN - 1; k++) begin
         if (!found && pc_trace[k] == 32'd52) begin
            found = 1'b1;
            k52   = k;
         end
      end
      chk(found, "R5 fetch reached 52", 32'(found), 32'd1);
      if (found) begin
         chk(pc_trace[k52 + 1] == 32'd56, "R5 redirect one cycle after BLT",
             pc_trace[k52 + 1], 32'd56);
         chk(pc_trace[k52 - 1] == 32'd48 && pc_trace[k52 - 2] == 32'd48 &&
             pc_trace[k52 - 3] == 32'd44, "R9 hold before BLT on loaded x7",
             pc_trace[k52 - 2], 32'd48);
      end

      chk(nst == N_EXP, "R6 store count (no off-path stores)", 32'(nst), 32'(N_EXP));
      for (int i = 0; i < N_EXP; i++) begin
         if (i < nst) begin
            chk(st_a[i] == EXP_ST[i][63:32], $sformatf("R4 store %0d address", i),
                st_a[i], EXP_ST[i][63:32]);
            chk(st_d[i] == EXP_ST[i][31:0], $sformatf("R3 R7 R8 store %0d data", i),
                st_d[i], EXP_ST[i][31:0]);
         end
      end
      for (int i = 0; i < nst && i < 32; i++) begin
         chk(!(st_a[i] == 32'd76 || st_a[i] == 32'd80 || st_a[i] == 32'd96 ||
               st_a[i] == 32'd100), "R6 off-path store seen", st_a[i], 32'd0);
      end
      chk(dram[19] == 32'd0, "R6 address 76 untouched", dram[19], 32'd0);
      chk(dram[26] == 32'd3, "R7 memory at 104", dram[26], 32'd3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule